// File: doc/BRIEF.md
# Core and Package Idle Power State Controller

This block decides, cycle by cycle, how far each processor core and the package around them may sleep. Every core runs its own small state machine. It moves from running to a clock-gated idle state once all of its hardware threads have halted. From that idle state it moves to an electrically isolated off state only when software asks for it. A package-level sequencer watches the cores together with a set of host controls. It gates the uncore clock and lowers the memory power state in steps as the whole chip goes quiet.

Entry into the first package idle level is automatic. It happens once no core is running or powering up, unless the host reports that the uncore is still busy. The deeper levels are entered only on an explicit request: host deep-idle from auto-idle, or package-off from either idle level. Each package level fixes the memory state. A wake request first returns the package and memory to full power. Only after that is the requesting core released, either directly from clock-gated idle or through a fixed power-up delay from the off state.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: While reset is asserted and after its release, every core reports status 0 (running), with clock gate and isolate low, and the package is running with the uncore clock ungated and memory code 0.
- R2: A running core whose all-threads-halted input is high has its clock gate raised and its 2-bit status set to 1 (clock-gated idle) at the next clock edge. Other cores are unaffected.
- R3: A power-off request to a clock-gated core sets its status to 2 (off) at the next edge. Its isolate output rises one edge later, so the status always leads isolation by one cycle.
- R4: A power-off request to a running core has no effect.
- R5: When no core is running or powering up, no wake is pending and the host busy flag is low, the package enters auto-idle at the next edge. The uncore clock gate goes high and the memory code becomes 1.
- R6: While the host busy flag is high, the package stays running with memory code 0, even when every core is idle.
- R7: A host deep-idle request moves the package from auto-idle to deep-idle, with memory code 2. The same request has no effect while the package is running.
- R8: A package-off request in auto-idle or deep-idle sets memory code 3. Every core that is not yet off then reports status 2 one edge later and raises isolate the edge after that.
- R9: A wake request for any core while the package is idle returns the package to running (memory code 0, uncore ungated) at the next edge. The core's clock is ungated only at the edge after that.
- R10: A wake request to an off core, with the package running, drops its isolate at the next edge. Its clock stays gated for exactly PWRUP_CYCLES further edges, and then the core runs with status 0.
- R11: A wake request to a clock-gated core while the package is running ungates its clock and sets status 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_halted | input | NUM_CORES | Per core: all hardware threads halted |
| core_off_req | input | NUM_CORES | Per core: software request to power the core off |
| core_wake_req | input | NUM_CORES | Per core: wake request, held until served |
| host_uncore_busy | input | 1 | Host veto of automatic package idle |
| host_deep_req | input | 1 | Host request for deep package idle |
| pkg_off_req | input | 1 | Request for package off |
| core_clk_gate | output | NUM_CORES | Per core clock gate enable |
| core_iso | output | NUM_CORES | Per core power isolate enable |
| uncore_clk_gate | output | 1 | Uncore clock gate enable |
| mem_state | output | 2 | Memory power code 0..3 |
| core_status | output | 2*NUM_CORES | Per core status, 2 bits each, core 0 in the low bits |

## Verification
On every cycle, the assertions check the safety rules that tie the levels together. An isolated core is always clock-gated. No core runs while memory is below full power. Isolation never rises without the status having shown off one cycle earlier. A core clock is ungated only after a cycle at memory code 0. Deep-idle is reached only through auto-idle, and auto-idle is never entered over a host veto. Only the bench scenarios can show the liveness side: that halting, requests and wakes actually produce the transitions at the right edge, that requests which must be ignored are ignored, and that the power-up delay has exactly its set length.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;
  typedef enum logic [2:0] {
    CS_RUN    = 3'd0,
    CS_GATED  = 3'd1,
    CS_PREOFF = 3'd2,
    CS_OFF    = 3'd3,
    CS_PWRUP  = 3'd4
  } core_st_e;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_AUTO = 2'd1,
    PS_DEEP = 2'd2,
    PS_OFF  = 2'd3
  } pkg_st_e;

  localparam logic [1:0] STAT_RUN   = 2'd0;
  localparam logic [1:0] STAT_GATED = 2'd1;
  localparam logic [1:0] STAT_OFF   = 2'd2;

  localparam logic [1:0] MEM_ON     = 2'd0;
  localparam logic [1:0] MEM_CGATE  = 2'd1;
  localparam logic [1:0] MEM_SREF   = 2'd2;
  localparam logic [1:0] MEM_STOP   = 2'd3;
endpackage

// File: rtl/core_pwr_fsm.sv
module core_pwr_fsm
  import idle_pwr_pkg::*;
#(
  parameter int PWRUP_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halted,
  input  logic       off_req,
  input  logic       wake_req,
  input  logic       pkg_run,
  input  logic       pkg_shut,
  output logic       clk_gate,
  output logic       iso,
  output logic [1:0] status,
  output logic       idle
);
  localparam int CW = $clog2(PWRUP_CYCLES + 1);

  core_st_e        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CS_RUN:    if (halted) st_d = CS_GATED;
      CS_GATED:  begin
        if (pkg_shut || off_req)      st_d = CS_PREOFF;
        else if (wake_req && pkg_run) st_d = CS_RUN;
      end
      CS_PREOFF: st_d = CS_OFF;
      CS_OFF:    if (wake_req && pkg_run) st_d = CS_PWRUP;
      CS_PWRUP:  if (cnt_q == '0) st_d = CS_RUN;
      default:   st_d = CS_RUN;
    endcase
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (st_q != CS_PWRUP && st_d == CS_PWRUP) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(PWRUP_CYCLES - 1);
    end else if (st_q == CS_PWRUP && cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CS_RUN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    clk_gate = (st_q != CS_RUN);
    iso      = (st_q == CS_OFF);
    idle     = (st_q == CS_GATED) || (st_q == CS_PREOFF) || (st_q == CS_OFF);
    unique case (st_q)
      CS_RUN:   status = STAT_RUN;
      CS_GATED: status = STAT_GATED;
      default:  status = STAT_OFF;
    endcase
  end
endmodule

// File: rtl/pkg_pwr_fsm.sv
module pkg_pwr_fsm
  import idle_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       all_idle,
  input  logic       any_wake,
  input  logic       host_busy,
  input  logic       deep_req,
  input  logic       off_req,
  output logic       pkg_run,
  output logic       pkg_shut,
  output logic       uncore_gate,
  output logic [1:0] mem_code
);
  pkg_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_RUN:  if (all_idle && !any_wake && !host_busy) st_d = PS_AUTO;
      PS_AUTO: begin
        if (any_wake)     st_d = PS_RUN;
        else if (off_req) st_d = PS_OFF;
        else if (deep_req) st_d = PS_DEEP;
      end
      PS_DEEP: begin
        if (any_wake)     st_d = PS_RUN;
        else if (off_req) st_d = PS_OFF;
      end
      PS_OFF:  if (any_wake) st_d = PS_RUN;
      default: st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_RUN;
    else        st_q <= st_d;
  end

  always_comb begin
    pkg_run     = (st_q == PS_RUN);
    pkg_shut    = (st_q == PS_OFF);
    uncore_gate = (st_q != PS_RUN);
    unique case (st_q)
      PS_RUN:  mem_code = MEM_ON;
      PS_AUTO: mem_code = MEM_CGATE;
      PS_DEEP: mem_code = MEM_SREF;
      default: mem_code = MEM_STOP;
    endcase
  end
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
  import idle_pwr_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int PWRUP_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CORES-1:0]   core_halted,
  input  logic [NUM_CORES-1:0]   core_off_req,
  input  logic [NUM_CORES-1:0]   core_wake_req,
  input  logic                   host_uncore_busy,
  input  logic                   host_deep_req,
  input  logic                   pkg_off_req,
  output logic [NUM_CORES-1:0]   core_clk_gate,
  output logic [NUM_CORES-1:0]   core_iso,
  output logic                   uncore_clk_gate,
  output logic [1:0]             mem_state,
  output logic [2*NUM_CORES-1:0] core_status
);
  logic [NUM_CORES-1:0] core_idle;
  logic                 pkg_run;
  logic                 pkg_shut;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    core_pwr_fsm #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .halted   (core_halted[i]),
      .off_req  (core_off_req[i]),
      .wake_req (core_wake_req[i]),
      .pkg_run  (pkg_run),
      .pkg_shut (pkg_shut),
      .clk_gate (core_clk_gate[i]),
      .iso      (core_iso[i]),
      .status   (core_status[2*i +: 2]),
      .idle     (core_idle[i])
    );
  end

  pkg_pwr_fsm u_pkg (
    .clk         (clk),
    .rst_n       (rst_n),
    .all_idle    (&core_idle),
    .any_wake    (|core_wake_req),
    .host_busy   (host_uncore_busy),
    .deep_req    (host_deep_req),
    .off_req     (pkg_off_req),
    .pkg_run     (pkg_run),
    .pkg_shut    (pkg_shut),
    .uncore_gate (uncore_clk_gate),
    .mem_code    (mem_state)
  );
endmodule

// File: rtl/idle_pwr_chk.sv
module idle_pwr_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_uncore_busy,
  input logic [NUM_CORES-1:0]   core_clk_gate,
  input logic [NUM_CORES-1:0]   core_iso,
  input logic [1:0]             mem_state,
  input logic [2*NUM_CORES-1:0] core_status
);
  // R8
  mem_low_cores_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_state != 2'd0) |-> (&core_clk_gate));

  // R7
  deep_via_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_state == 2'd2) |-> ($past(mem_state) == 2'd1 || $past(mem_state) == 2'd2));

  // R6
  no_veto_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_state == 2'd1 && $past(mem_state) == 2'd0) |-> !$past(host_uncore_busy));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    // R3
    iso_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_iso[i] |-> core_clk_gate[i]);

    // R3
    status_before_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_iso[i]) |-> ($past(core_status[2*i +: 2]) == 2'd2));

    // R9
    ungate_after_mem_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_clk_gate[i]) |-> ($past(mem_state) == 2'd0));
  end
endmodule

bind idle_pwr_ctrl idle_pwr_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .host_uncore_busy (host_uncore_busy),
  .core_clk_gate    (core_clk_gate),
  .core_iso         (core_iso),
  .mem_state        (mem_state),
  .core_status      (core_status)
);

// File: tb/sim_idle_pwr_ctrl.sv
module sim_idle_pwr_ctrl;
  localparam int N  = 4;
  localparam int PU = 16;
  localparam int NV = 21;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] halted, offr, wake;
  logic         busy, deep, pkoff;
  logic [N-1:0] gate, iso;
  logic         unc;
  logic [1:0]   mem;
  logic [2*N-1:0] stat;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 0;

  idle_pwr_ctrl #(.NUM_CORES(N), .PWRUP_CYCLES(PU)) u0 (
    .clk(clk), .rst_n(rst_n), .core_halted(halted), .core_off_req(offr),
    .core_wake_req(wake), .host_uncore_busy(busy), .host_deep_req(deep),
    .pkg_off_req(pkoff), .core_clk_gate(gate), .core_iso(iso),
    .uncore_clk_gate(unc), .mem_state(mem), .core_status(stat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // row: {halted, off, wake, busy, deep, pkoff} then expected {gate, iso, status, mem, uncore}
  localparam logic [33:0] VEC [NV] = '{
    {4'b0001,4'b0000,4'b0000,3'b000, 4'b0001,4'b0000,8'h01,2'd0,1'b0}, // 0  R2
    {4'b0001,4'b0010,4'b0000,3'b000, 4'b0001,4'b0000,8'h01,2'd0,1'b0}, // 1  R4
    {4'b0001,4'b0001,4'b0000,3'b000, 4'b0001,4'b0000,8'h02,2'd0,1'b0}, // 2  R3
    {4'b0001,4'b0000,4'b0000,3'b000, 4'b0001,4'b0001,8'h02,2'd0,1'b0}, // 3  R3
    {4'b0011,4'b0000,4'b0000,3'b100, 4'b0011,4'b0001,8'h06,2'd0,1'b0}, // 4  R2
    {4'b1111,4'b0000,4'b0000,3'b100, 4'b1111,4'b0001,8'h56,2'd0,1'b0}, // 5  R2
    {4'b1111,4'b0000,4'b0000,3'b100, 4'b1111,4'b0001,8'h56,2'd0,1'b0}, // 6  R6
    {4'b1111,4'b0000,4'b0000,3'b000, 4'b1111,4'b0001,8'h56,2'd1,1'b1}, // 7  R5
    {4'b1111,4'b0000,4'b0000,3'b010, 4'b1111,4'b0001,8'h56,2'd2,1'b1}, // 8  R7
    {4'b1111,4'b0000,4'b0010,3'b000, 4'b1111,4'b0001,8'h56,2'd0,1'b0}, // 9  R9
    {4'b1101,4'b0000,4'b0010,3'b000, 4'b1101,4'b0001,8'h52,2'd0,1'b0}, // 10 R9
    {4'b1101,4'b0000,4'b0000,3'b000, 4'b1101,4'b0001,8'h52,2'd0,1'b0}, // 11 R9
    {4'b1101,4'b0000,4'b0000,3'b010, 4'b1101,4'b0001,8'h52,2'd0,1'b0}, // 12 R7
    {4'b1101,4'b0000,4'b0100,3'b000, 4'b1001,4'b0001,8'h42,2'd0,1'b0}, // 13 R11
    {4'b1111,4'b0000,4'b0000,3'b000, 4'b1111,4'b0001,8'h56,2'd0,1'b0}, // 14 R2
    {4'b1111,4'b0000,4'b0000,3'b000, 4'b1111,4'b0001,8'h56,2'd1,1'b1}, // 15 R5
    {4'b1111,4'b0000,4'b0000,3'b001, 4'b1111,4'b0001,8'h56,2'd3,1'b1}, // 16 R8
    {4'b1111,4'b0000,4'b0000,3'b000, 4'b1111,4'b0001,8'hAA,2'd3,1'b1}, // 17 R8
    {4'b1111,4'b0000,4'b0000,3'b000, 4'b1111,4'b1111,8'hAA,2'd3,1'b1}, // 18 R8
    {4'b1110,4'b0000,4'b0001,3'b000, 4'b1111,4'b1111,8'hAA,2'd0,1'b0}, // 19 R9
    {4'b1110,4'b0000,4'b0001,3'b000, 4'b1111,4'b1110,8'hAA,2'd0,1'b0}  // 20 R10
  };
  localparam int REQ [NV] = '{2,4,3,3,2,2,6,5,7,9,9,9,7,11,2,5,8,8,8,9,10};

  task automatic check(input string tag, input logic [18:0] exp);
    logic [18:0] act;
    act = {gate, iso, stat, mem, unc};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got gate=%b iso=%b stat=%h mem=%0d unc=%b, expected gate=%b iso=%b stat=%h mem=%0d unc=%b",
               tag, act[18:15], act[14:11], act[10:3], act[2:1], act[0],
               exp[18:15], exp[14:11], exp[10:3], exp[2:1], exp[0]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    rst_n = 1'b0;
    halted = '0; offr = '0; wake = '0; busy = 1'b0; deep = 1'b0; pkoff = 1'b0;
    #3;
    // R1: state during reset
    check("R1 in reset", {4'b0000, 4'b0000, 8'h00, 2'd0, 1'b0});
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1: state after release
    check("R1 after release", {4'b0000, 4'b0000, 8'h00, 2'd0, 1'b0});

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {halted, offr, wake, busy, deep, pkoff} = VEC[k][33:19];
      tick();
      check($sformatf("R%0d row %0d", REQ[k], k), VEC[k][18:0]);
    end

    // R10: power-up delay, core 0 entered power-up at the last row's edge
    @(negedge clk);
    wake = '0;
    halted = 4'b1110;
    for (int c = 1; c < PU; c++) tick();
    check("R10 still gated at delay end-1", {4'b1111, 4'b1110, 8'hAA, 2'd0, 1'b0});
    tick();
    check("R10 ungated after delay", {4'b1110, 4'b1110, 8'hA8, 2'd0, 1'b0});

    // R4: off request to the running core 0 is ignored
    @(negedge clk);
    offr = 4'b0001;
    tick();
    check("R4 off to running core", {4'b1110, 4'b1110, 8'hA8, 2'd0, 1'b0});
    @(negedge clk);
    offr = '0;

    // R1: asynchronous reset mid-run
    #1;
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", {4'b0000, 4'b0000, 8'h00, 2'd0, 1'b0});
    @(negedge clk);
    halted = '0;
    rst_n = 1'b1;
    tick();
    check("R1 after second release", {4'b0000, 4'b0000, 8'h00, 2'd0, 1'b0});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule